// File: doc/BRIEF.md
# I2C Target Register Port with Address Pointer

This block is the control-port end of an I2C link. A host controller uses it to read and write a bank of up to 128 byte-wide registers that sit behind a simple internal bus. The block watches the open-drain SCL and SDA lines, and it pulls SDA low only to acknowledge a byte or to send a zero data bit. It never stretches the clock.

The device address is seven bits long. Six of them are fixed by a parameter, and the lowest bit follows a strap input. A write transfer carries a pointer byte first. That byte holds a register index and an auto-advance flag, and every byte after it is stored at the pointed register. A read transfer returns register contents starting at the current pointer, so a random-access read is a pointer-only write followed by a repeated START and a read address. A read with no pointer write before it starts from the pointer left by the last write, or from the reset value if no write has happened yet.

Top module: `i2c_reg_target`

## Requirements
- R1: The address byte is {DEV_HI (6'b001100 by default), addrStrap, R/W}, sent MSB first, where R/W is 0 for write and 1 for read. On a match the block holds SDA low through the ninth clock (ACK). On any other address it leaves SDA released for the rest of the transfer.
- R2: In a write transfer, the byte after the address is the pointer. Bit 7 is the auto-advance flag and bits 6:0 are the register index. The block acknowledges the pointer byte.
- R3: Each later byte of a write transfer is acknowledged and produces one single-cycle regWrEn pulse, with regWrAddr set to the pointer index and regWrData set to the byte.
- R4: When the auto-advance flag is 1, the index steps by one after every stored or sent byte and wraps from 127 to 0.
- R5: When the auto-advance flag is 0, the index does not move, so repeated data bytes go to the same register.
- R6: A read transfer sends the register at the current index MSB first. After reset the pointer is index 0x01 with auto-advance off.
- R7: During a read, a controller ACK makes the block send the next byte. A controller NACK ends the transfer and leaves SDA released.
- R8: A pointer-only write followed by a repeated START and a read address returns data starting at the newly written index.
- R9: A STOP or START in the middle of a byte drops the partial byte (no register write), and a START begins a new address phase.
- R10: A transfer with a non-matching address changes neither the pointer nor any register.
- R11: sdaOe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| addrStrap | input | 1 | Strap that sets the lowest address bit |
| regWrEn | output | 1 | Register write strobe, one cycle per byte |
| regWrAddr | output | IDX_W | Register write index |
| regWrData | output | 8 | Register write data |
| regRdAddr | output | IDX_W | Register read index (the current pointer) |
| regRdData | input | 8 | Register read data for regRdAddr |

## Verification
The bench builds the block with its default parameters: a 7-bit index, a reset index of 0x01 and a two-stage synchroniser. With a 7-bit index, a three-byte burst that starts at index 0x7E reaches the wrap from 127 to 0, both on the write path and on the read path. The strap input is driven to both levels, so address match and mismatch are each covered for the two strap values. Truncated bytes cut short by STOP and by a repeated START are also exercised.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic ackDrive;
    logic oeRelease;
    logic mapLoad;
    logic mapInc;
    logic regWr;
  } i2ctStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_MAP,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_RACK
  } i2ctState_t;
endpackage

// File: rtl/i2ct_datapath.sv
module i2ct_datapath
  import i2ct_pkg::*;
#(
  parameter int IDX_W       = 7,
  parameter int RESET_IDX   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  i2ctStrobe_t      st,
  input  logic [7:0]       regRdData,
  output logic             sclRise,
  output logic             sclFall,
  output logic             startDet,
  output logic             stopDet,
  output logic             sdaBit,
  output logic [7:0]       rxNext,
  output logic             sdaOe,
  output logic             regWrEn,
  output logic [IDX_W-1:0] regWrAddr,
  output logic [7:0]       regWrData,
  output logic [IDX_W-1:0] regRdAddr
);
  localparam int PW = SYNC_STAGES + 1;

  logic [PW-1:0]    sclPipe, sdaPipe;
  logic             sclS, sclD, sdaS, sdaD;
  logic [6:0]       rxSh;
  logic [6:0]       txSh;
  logic             mapIncr;
  logic [IDX_W-1:0] mapIdx;

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sclD = sclPipe[SYNC_STAGES];
  assign sdaS = sdaPipe[SYNC_STAGES-1];
  assign sdaD = sdaPipe[SYNC_STAGES];

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign sdaBit   = sdaS;
  assign rxNext   = {rxSh, sdaS};
  assign regRdAddr = mapIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe   <= '1;
      sdaPipe   <= '1;
      rxSh      <= '0;
      txSh      <= '0;
      mapIncr   <= 1'b0;
      mapIdx    <= IDX_W'(RESET_IDX);
      sdaOe     <= 1'b0;
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
    end else begin
      sclPipe <= {sclPipe[PW-2:0], sclIn};
      sdaPipe <= {sdaPipe[PW-2:0], sdaIn};
      regWrEn <= st.regWr;
      if (st.regWr) begin
        regWrAddr <= mapIdx;
        regWrData <= rxNext;
      end
      if (st.rxShift) rxSh <= rxNext[6:0];
      if (st.mapLoad) begin
        mapIncr <= rxNext[7];
        mapIdx  <= rxNext[IDX_W-1:0];
      end else if (st.mapInc && mapIncr) begin
        mapIdx <= mapIdx + 1'b1;
      end
      if (st.txLoad)       txSh <= regRdData[6:0];
      else if (st.txShift) txSh <= {txSh[5:0], 1'b0};
      if (st.oeRelease)    sdaOe <= 1'b0;
      else if (st.ackDrive) sdaOe <= 1'b1;
      else if (st.txLoad)  sdaOe <= ~regRdData[7];
      else if (st.txShift) sdaOe <= ~txSh[6];
    end
  end
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
#(
  parameter logic [5:0] DEV_HI = 6'b001100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic        sdaBit,
  input  logic [7:0]  rxNext,
  input  logic        addrStrap,
  output i2ctStrobe_t st
);
  i2ctState_t state, nState, ackNext, nAckNext;
  logic [2:0] cnt, nCnt;
  logic       phase, nPhase;

  always_comb begin
    st       = '0;
    nState   = state;
    nCnt     = cnt;
    nPhase   = phase;
    nAckNext = ackNext;
    if (stopDet) begin
      nState       = ST_IDLE;
      st.oeRelease = 1'b1;
    end else if (startDet) begin
      nState       = ST_ADDR;
      nCnt         = '0;
      st.oeRelease = 1'b1;
    end else begin
      case (state)
        ST_ADDR: if (sclRise) begin
          st.rxShift = 1'b1;
          nCnt = cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (rxNext[7:1] == {DEV_HI, addrStrap}) begin
              nState   = ST_ACK;
              nPhase   = 1'b0;
              nAckNext = rxNext[0] ? ST_TX : ST_MAP;
            end else begin
              nState = ST_IDLE;
            end
          end
        end
        ST_MAP, ST_WDATA: if (sclRise) begin
          st.rxShift = 1'b1;
          nCnt = cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (state == ST_MAP) st.mapLoad = 1'b1;
            else begin
              st.regWr  = 1'b1;
              st.mapInc = 1'b1;
            end
            nState   = ST_ACK;
            nPhase   = 1'b0;
            nAckNext = ST_WDATA;
          end
        end
        ST_ACK: if (sclFall) begin
          if (!phase) begin
            st.ackDrive = 1'b1;
            nPhase = 1'b1;
          end else begin
            nCnt   = '0;
            nPhase = 1'b0;
            nState = ackNext;
            if (ackNext == ST_TX) begin
              st.txLoad = 1'b1;
              st.mapInc = 1'b1;
            end else begin
              st.oeRelease = 1'b1;
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            nCnt = cnt + 3'd1;
            if (cnt == 3'd7) begin
              nState = ST_RACK;
              nPhase = 1'b0;
            end
          end
          if (sclFall) st.txShift = 1'b1;
        end
        ST_RACK: begin
          if (sclFall && !phase) st.oeRelease = 1'b1;
          if (sclRise) begin
            if (sdaBit) nState = ST_IDLE;
            else        nPhase = 1'b1;
          end
          if (sclFall && phase) begin
            st.txLoad = 1'b1;
            st.mapInc = 1'b1;
            nCnt      = '0;
            nPhase    = 1'b0;
            nState    = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ackNext <= ST_IDLE;
      cnt     <= '0;
      phase   <= 1'b0;
    end else begin
      state   <= nState;
      ackNext <= nAckNext;
      cnt     <= nCnt;
      phase   <= nPhase;
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2ct_pkg::*;
#(
  parameter int         IDX_W       = 7,
  parameter int         RESET_IDX   = 1,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_HI      = 6'b001100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  input  logic             addrStrap,
  output logic             regWrEn,
  output logic [IDX_W-1:0] regWrAddr,
  output logic [7:0]       regWrData,
  output logic [IDX_W-1:0] regRdAddr,
  input  logic [7:0]       regRdData
);
  i2ctStrobe_t st;
  logic sclRise, sclFall, startDet, stopDet, sdaBit;
  logic [7:0] rxNext;

  i2ct_ctrl #(.DEV_HI(DEV_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .rxNext(rxNext), .addrStrap(addrStrap), .st(st)
  );

  i2ct_datapath #(.IDX_W(IDX_W), .RESET_IDX(RESET_IDX), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .st(st),
    .regRdData(regRdData), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit), .rxNext(rxNext),
    .sdaOe(sdaOe), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr)
  );
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaOe,
  input logic             regWrEn,
  input logic [IDX_W-1:0] regWrAddr,
  input logic [IDX_W-1:0] regRdAddr
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn); // R11

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R3

  AST_WR_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> sclIn); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regRdAddr == regWrAddr) ||
                (regRdAddr == IDX_W'(regWrAddr + 1'b1))); // R4
endmodule

bind i2c_reg_target i2ct_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regRdAddr(regRdAddr)
);

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
  localparam time Q = 160ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, strap = 1'b0;
  logic sdaOe, regWrEn;
  logic [6:0] regWrAddr, regRdAddr;
  logic [7:0] regWrData, regRdData;
  logic sdaLine;
  logic [7:0] mem [0:127];
  int nChk = 0, nFail = 0, sclViol = 0;
  logic oePrev = 1'b0;
  bit done = 0;

  always #10ns clk = ~clk;

  assign sdaLine   = sdaM & ~sdaOe;
  assign regRdData = mem[regRdAddr];

  i2c_reg_target u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrStrap(strap), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  function automatic logic [7:0] initVal(input int i);
    return 8'(8'h5C ^ (i * 7));
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 128; i++) mem[i] <= initVal(i);
    end else if (regWrEn) begin
      mem[regWrAddr] <= regWrData;
    end
  end

  // R11 monitor: sdaOe must not move while SCL is high
  always @(posedge clk) begin
    oePrev <= sdaOe;
    if (rstN && (sdaOe != oePrev) && sclM) sclViol <= sclViol + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start();
    sdaM = 1'b1; #Q; sclM = 1'b1; #Q; sdaM = 1'b0; #Q; sclM = 1'b0; #Q;
  endtask

  task automatic stop();
    sdaM = 1'b0; #Q; sclM = 1'b1; #Q; sdaM = 1'b1; #Q;
  endtask

  task automatic slot(input logic b, output logic seen);
    sdaM = b; #Q; sclM = 1'b1; #Q; seen = sdaLine; #Q; sclM = 1'b0; #Q;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) slot(b[i], s);
    slot(1'b1, ack);
  endtask

  task automatic recvByte(input logic ackBit, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      slot(1'b1, s);
      b[i] = s;
    end
    slot(ackBit, s);
  endtask

  function automatic logic [7:0] adr(input logic sb, input logic rw);
    return {6'b001100, sb, rw};
  endfunction

  // {pointer byte (no auto-advance), data}
  localparam logic [15:0] VEC [6] = '{
    16'h10_A5, 16'h11_3C, 16'h7F_00, 16'h00_FF, 16'h55_81, 16'h2A_7E
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d, d2, d3;
    repeat (5) @(posedge clk);
    #3ns rstN = 1'b1;
    repeat (3) @(posedge clk);
    #5ns;
    chk("R6 reset pointer", regRdAddr, 1);
    chk("R7 reset sdaOe", sdaOe, 0);

    // R6: current read right after reset
    start(); sendByte(adr(0, 1), a); chk("R1 read addr ack", a, 0);
    recvByte(1'b1, d); stop();
    chk("R6 read at reset pointer", d, initVal(1));
    chk("R7 released after NACK", sdaOe, 0);

    // R2 R3 R8: table walk, write then random-address read back
    foreach (VEC[k]) begin
      logic a1, a2, a3;
      start(); sendByte(adr(0, 0), a1); sendByte(VEC[k][15:8], a2);
      sendByte(VEC[k][7:0], a3); stop();
      chk("R2 pointer ack", a2, 0);
      chk("R3 data ack", a3, 0);
      chk("R3 stored", mem[VEC[k][14:8]], VEC[k][7:0]);
      start(); sendByte(adr(0, 0), a1); sendByte(VEC[k][15:8], a2);
      start(); sendByte(adr(0, 1), a3); recvByte(1'b1, d); stop();
      chk("R8 random read", d, VEC[k][7:0]);
    end

    // R4: burst with wrap 0x7E, 0x7F, 0x00
    start(); sendByte(adr(0, 0), a); sendByte(8'hFE, a);
    sendByte(8'h11, a); sendByte(8'h22, a); sendByte(8'h33, a); stop();
    chk("R4 burst 7E", mem[126], 8'h11);
    chk("R4 burst 7F", mem[127], 8'h22);
    chk("R4 burst wrap 00", mem[0], 8'h33);

    // R5: no auto-advance, two bytes to one register
    start(); sendByte(adr(0, 0), a); sendByte(8'h20, a);
    sendByte(8'h44, a); sendByte(8'h55, a); stop();
    chk("R5 same register", mem[32], 8'h55);
    chk("R5 neighbour untouched", mem[33], initVal(33));

    // R6/R7: current read uses last written pointer, no advance
    start(); sendByte(adr(0, 1), a); recvByte(1'b0, d); recvByte(1'b1, d2); stop();
    chk("R6 read last pointer", d, 8'h55);
    chk("R7 ACK repeats same reg", d2, 8'h55);

    // R7/R8: sequential read across the wrap
    start(); sendByte(adr(0, 0), a); sendByte(8'hFE, a);
    start(); sendByte(adr(0, 1), a);
    recvByte(1'b0, d); recvByte(1'b0, d2); recvByte(1'b1, d3); stop();
    chk("R7 seq byte0", d, 8'h11);
    chk("R7 seq byte1", d2, 8'h22);
    chk("R4 seq byte2 wrap", d3, 8'h33);
    chk("R7 released after seq", sdaOe, 0);

    // R1/R10: wrong strap bit, ignored
    start(); sendByte(adr(1, 0), a); chk("R1 mismatch NACK", a, 1);
    sendByte(8'h05, a); chk("R10 no ack on pointer", a, 1);
    sendByte(8'h99, a); stop();
    chk("R10 register untouched", mem[5], initVal(5));
    start(); sendByte(adr(0, 1), a); recvByte(1'b1, d); stop();
    chk("R10 pointer unchanged", d, initVal(1));

    // R1: strap high
    strap = 1'b1;
    start(); sendByte(adr(1, 0), a); chk("R1 strap high ack", a, 0);
    sendByte(8'h30, a); sendByte(8'h5A, a); stop();
    chk("R1 strap high write", mem[48], 8'h5A);
    start(); sendByte(adr(0, 0), a); stop();
    chk("R1 strap high old addr NACK", a, 1);
    strap = 1'b0;

    // R9: STOP mid-byte
    start(); sendByte(adr(0, 0), a); sendByte(8'h40, a);
    for (int i = 0; i < 4; i++) slot(1'b0, a);
    stop();
    chk("R9 partial byte dropped", mem[64], initVal(64));
    start(); sendByte(adr(0, 1), a); recvByte(1'b1, d); stop();
    chk("R9 pointer kept", d, initVal(64));

    // R9: START mid-byte restarts address phase
    start(); sendByte(adr(0, 0), a); sendByte(8'h41, a);
    for (int i = 0; i < 3; i++) slot(1'b1, a);
    start(); sendByte(adr(0, 0), a); chk("R9 restart ack", a, 0);
    sendByte(8'h42, a); sendByte(8'hC3, a); stop();
    chk("R9 no write from partial", mem[65], initVal(65));
    chk("R9 write after restart", mem[66], 8'hC3);

    chk("R11 sdaOe moved with SCL high", sclViol, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule